// File: doc/BRIEF.md
# Bank-Switching Window Mapper

This block lets a processor with a 20-bit (1 MB) address space reach a larger expansion memory through two fixed 16 KB windows. Window 0 sits at processor addresses 0xD0000–0xD3FFF and window 1 at 0xD4000–0xD7FFF. Each window owns an 8-bit bank register, so it can be aimed at any one of 256 blocks of 16 KB. The same processor address can therefore land on many physical locations, depending on what software last wrote into the bank register.

On each processor access the mapper checks whether the address lies inside an enabled window. If it does, the mapper raises the expansion chip select and drives a 22-bit expansion address. That address is the window's bank number placed above the low 14 processor address bits. Any other access goes to base memory. Software updates a window through a small register port. A write carries an enable flag in bit 8 and a bank number in bits 7:0, and a select input picks the window. A read port returns the same 9-bit layout for either window.

Each window is controlled by a two-state machine with the states WIN_OFF and WIN_ON. The ARM transition (WIN_OFF to WIN_ON) happens on a write to that window with bit 8 set. The DISARM transition (WIN_ON to WIN_OFF) happens on a write to that window with bit 8 clear. Any other cycle keeps the current state.

Top module: `bsw_window_mapper`

## Requirements
- R1: After reset, both bank registers hold 0 and both windows are in WIN_OFF. Reading either window returns 0x000, and an access to 0xD0000 goes to base memory.
- R2: An access inside an enabled window asserts exp_cs, deasserts base_cs, and drives exp_addr = {bank[7:0], cpu_addr[13:0]}.
- R3: An access inside a window that is in WIN_OFF goes to base memory: base_cs=1, exp_cs=0. This holds whatever the stored bank number is.
- R4: An access outside 0xD0000–0xD7FFF always goes to base memory.
- R5: While cpu_req=1, exactly one of exp_cs and base_cs is high. While cpu_req=0, both are low. exp_addr is 0 whenever exp_cs is low.
- R6: A write with wr_sel=0 loads only window 0, and a write with wr_sel=1 loads only window 1. wr_data[8] is the enable flag, which drives the ARM/DISARM transitions. wr_data[7:0] is the bank number. The other window keeps its contents.
- R7: rd_data returns {enable, bank} for the window chosen by rd_sel, with the enable flag in bit 8 and the bank in bits 7:0.
- R8: A write takes effect on the cycle after the clock edge that accepts it. An access in the same cycle as the write still uses the old bank and enable.
- R9: The window edges are exact. 0xD3FFF maps through window 0 and 0xD4000 maps through window 1.
- R10: Bank 0xFF combined with the top address of window 1 (0xD7FFF) gives the highest expansion address, 0x3FFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access valid |
| cpu_addr | input | 20 | Processor address |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Window chosen for the write |
| wr_data | input | 9 | Write data: bit 8 enable, bits 7:0 bank |
| rd_sel | input | 1 | Window chosen for the read |
| rd_data | output | 9 | Read data: bit 8 enable, bits 7:0 bank |
| exp_cs | output | 1 | Expansion memory chip select |
| exp_addr | output | 22 | Expansion memory address |
| base_cs | output | 1 | Base memory chip select |

## Verification
The assertions check several properties on every cycle:
- the two chip selects are mutually exclusive, and both are low while idle;
- the low address bits pass straight through to the expansion address;
- any address outside the window range goes to base memory;
- a selected window is always enabled;
- a window's register changes only on a write aimed at it, and then holds exactly the written value one cycle later.

The directed scenarios are needed for the rest:
- the translated address values for chosen bank numbers;
- the exact window edges;
- the highest reachable expansion address;
- the rule that an access in the same cycle as a write sees the old bank.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
    // Window control state: a window redirects accesses only in WIN_ON.
    typedef enum logic {
        WIN_OFF = 1'b0,
        WIN_ON  = 1'b1
    } win_state_e;

    localparam int unsigned DEF_CPU_AW  = 20;
    localparam int unsigned DEF_WIN_AW  = 14;
    localparam int unsigned DEF_BANK_W  = 8;
    localparam int unsigned DEF_NUM_WIN = 2;
    localparam int unsigned DEF_WIN_BASE = 32'h000D_0000;
endpackage

// File: rtl/bsw_bank_latch.sv
module bsw_bank_latch
    import bsw_pkg::*;
#(
    parameter int unsigned BANK_W = DEF_BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              wr_enable_bit,
    input  logic [BANK_W-1:0] wr_bank,
    output logic [BANK_W-1:0] bank_q,
    output logic              en_q
);
    win_state_e state_q;
    win_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ARM (OFF->ON) and DISARM (ON->OFF)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_OFF: if (wr_hit && wr_enable_bit)  state_d = WIN_ON;
            WIN_ON:  if (wr_hit && !wr_enable_bit) state_d = WIN_OFF;
            default: state_d = WIN_OFF;
        endcase
    end

    // Bank number register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (wr_hit) begin
            bank_q <= wr_bank;
        end
    end

    // Outputs
    always_comb begin
        en_q = (state_q == WIN_ON);
    end

    // R6: contents hold when this window is not written
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(bank_q) && $stable(en_q)));

    // R8: a write is visible on the following cycle, exactly as written
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (bank_q == $past(wr_bank) && en_q == $past(wr_enable_bit)));
endmodule

// File: rtl/bsw_win_decode.sv
module bsw_win_decode
    import bsw_pkg::*;
#(
    parameter int unsigned CPU_AW   = DEF_CPU_AW,
    parameter int unsigned WIN_AW   = DEF_WIN_AW,
    parameter int unsigned BANK_W   = DEF_BANK_W,
    parameter int unsigned NUM_WIN  = DEF_NUM_WIN,
    parameter int unsigned WIN_BASE = DEF_WIN_BASE,
    parameter int unsigned EXP_AW   = BANK_W + WIN_AW
) (
    input  logic                           cpu_req,
    input  logic [CPU_AW-1:0]              cpu_addr,
    input  logic [NUM_WIN-1:0]             win_en,
    input  logic [NUM_WIN-1:0][BANK_W-1:0] win_bank,
    output logic                           exp_cs,
    output logic [EXP_AW-1:0]              exp_addr,
    output logic                           base_cs
);
    localparam int unsigned TAG_W = CPU_AW - WIN_AW;
    localparam logic [TAG_W-1:0] TAG0 = TAG_W'(WIN_BASE >> WIN_AW);

    logic [NUM_WIN-1:0] hit;
    logic [NUM_WIN-1:0] sel;

    // One tag comparator per window
    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        localparam logic [TAG_W-1:0] TAG_K = TAG0 + TAG_W'(k);
        always_comb begin
            hit[k] = cpu_req && (cpu_addr[CPU_AW-1:WIN_AW] == TAG_K);
            sel[k] = hit[k] && win_en[k];
        end
    end

    always_comb begin
        exp_addr = '0;
        for (int k = 0; k < NUM_WIN; k++) begin
            if (sel[k]) begin
                exp_addr = exp_addr | {win_bank[k], cpu_addr[WIN_AW-1:0]};
            end
        end
        exp_cs  = |sel;
        base_cs = cpu_req && !exp_cs;
    end
endmodule

// File: rtl/bsw_window_mapper.sv
module bsw_window_mapper
    import bsw_pkg::*;
#(
    parameter int unsigned CPU_AW   = DEF_CPU_AW,
    parameter int unsigned WIN_AW   = DEF_WIN_AW,
    parameter int unsigned BANK_W   = DEF_BANK_W,
    parameter int unsigned NUM_WIN  = DEF_NUM_WIN,
    parameter int unsigned WIN_BASE = DEF_WIN_BASE,
    parameter int unsigned SEL_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
    parameter int unsigned EXP_AW   = BANK_W + WIN_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BANK_W:0]   wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BANK_W:0]   rd_data,
    output logic              exp_cs,
    output logic [EXP_AW-1:0] exp_addr,
    output logic              base_cs
);
    localparam int unsigned WIN_SPAN = 1 << WIN_AW;
    localparam logic [CPU_AW-1:0] RANGE_LO = CPU_AW'(WIN_BASE);
    localparam logic [CPU_AW-1:0] RANGE_HI = CPU_AW'(WIN_BASE + NUM_WIN * WIN_SPAN - 1);

    logic [NUM_WIN-1:0]             en_q;
    logic [NUM_WIN-1:0][BANK_W-1:0] bank_q;

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_latch
        logic hit_k;
        always_comb hit_k = wr_en && (wr_sel == SEL_W'(k));

        bsw_bank_latch #(
            .BANK_W (BANK_W)
        ) u_latch (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_hit        (hit_k),
            .wr_enable_bit (wr_data[BANK_W]),
            .wr_bank       (wr_data[BANK_W-1:0]),
            .bank_q        (bank_q[k]),
            .en_q          (en_q[k])
        );
    end

    bsw_win_decode #(
        .CPU_AW   (CPU_AW),
        .WIN_AW   (WIN_AW),
        .BANK_W   (BANK_W),
        .NUM_WIN  (NUM_WIN),
        .WIN_BASE (WIN_BASE),
        .EXP_AW   (EXP_AW)
    ) u_dec (
        .cpu_req  (cpu_req),
        .cpu_addr (cpu_addr),
        .win_en   (en_q),
        .win_bank (bank_q),
        .exp_cs   (exp_cs),
        .exp_addr (exp_addr),
        .base_cs  (base_cs)
    );

    // Read-back mux
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_WIN; k++) begin
            if (rd_sel == SEL_W'(k)) begin
                rd_data = {en_q[k], bank_q[k]};
            end
        end
    end

    // R5: chip selects exclusive while active, quiet while idle
    p_one_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> $onehot({exp_cs, base_cs}));
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> (!exp_cs && !base_cs && exp_addr == '0));

    // R4: addresses outside the window range go to base memory
    p_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && (cpu_addr < RANGE_LO || cpu_addr > RANGE_HI)) |-> base_cs);

    // R2: low address bits pass straight through on expansion accesses
    p_low_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exp_cs |-> (exp_addr[WIN_AW-1:0] == cpu_addr[WIN_AW-1:0]));

    // R3: no expansion access without an enabled window
    p_need_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exp_cs |-> (|en_q));
endmodule

// File: tb/sim_bsw_window_mapper.sv
module sim_bsw_window_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [8:0]  rd_data;
    logic        exp_cs;
    logic [21:0] exp_addr;
    logic        base_cs;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bsw_window_mapper u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_addr (cpu_addr),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .exp_cs   (exp_cs),
        .exp_addr (exp_addr),
        .base_cs  (base_cs)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_win(input logic sel, input logic en, input logic [7:0] bank);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = {en, bank};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic access(input logic [19:0] a);
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a;
        #1;
    endtask

    task automatic rd_chk(input string tag, input logic sel, input logic [8:0] exp);
        rd_sel = sel;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic t_reset;
        rd_chk("R1 rd win0", 1'b0, 9'h000);
        rd_chk("R1 rd win1", 1'b1, 9'h000);
        access(20'hD0000);
        chk("R1 base_cs", 32'(base_cs), 1);
        chk("R1 exp_cs", 32'(exp_cs), 0);
    endtask

    task automatic t_disabled;
        wr_win(1'b0, 1'b0, 8'h05);
        rd_chk("R3 rd win0", 1'b0, 9'h005);
        access(20'hD0010);
        chk("R3 base_cs", 32'(base_cs), 1);
        chk("R3 exp_cs", 32'(exp_cs), 0);
    endtask

    task automatic t_map;
        wr_win(1'b0, 1'b1, 8'h12);
        wr_win(1'b1, 1'b1, 8'h34);
        access(20'hD0123);
        chk("R2 exp_cs", 32'(exp_cs), 1);
        chk("R2 base_cs", 32'(base_cs), 0);
        chk("R2 exp_addr w0", 32'(exp_addr), 32'h48123);
        access(20'hD5678);
        chk("R2 exp_addr w1", 32'(exp_addr), 32'hD1678);
        rd_chk("R7 rd win0", 1'b0, 9'h112);
        rd_chk("R7 rd win1", 1'b1, 9'h134);
    endtask

    task automatic t_bounds;
        access(20'hCFFFF);
        chk("R4 below base", 32'(base_cs), 1);
        access(20'hD8000);
        chk("R4 above base", 32'(base_cs), 1);
        access(20'h00000);
        chk("R4 zero base", 32'(base_cs), 1);
        access(20'hD3FFF);
        chk("R9 D3FFF addr", 32'(exp_addr), 32'h4BFFF);
        access(20'hD4000);
        chk("R9 D4000 addr", 32'(exp_addr), 32'hD0000);
    endtask

    task automatic t_idle;
        @(negedge clk);
        cpu_req = 1'b0; cpu_addr = 20'hD0000;
        #1;
        chk("R5 idle exp_cs", 32'(exp_cs), 0);
        chk("R5 idle base_cs", 32'(base_cs), 0);
        chk("R5 idle exp_addr", 32'(exp_addr), 0);
    endtask

    task automatic t_isolate;
        wr_win(1'b1, 1'b1, 8'h55);
        rd_chk("R6 win0 kept", 1'b0, 9'h112);
        rd_chk("R6 win1 loaded", 1'b1, 9'h155);
    endtask

    task automatic t_timing;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = {1'b1, 8'h77};
        cpu_req = 1'b1; cpu_addr = 20'hD0001;
        #1;
        chk("R8 same cycle old bank", 32'(exp_addr), 32'h48001);
        @(posedge clk);
        #1;
        chk("R8 next cycle new bank", 32'(exp_addr), 32'h1DC001);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_top;
        wr_win(1'b1, 1'b1, 8'hFF);
        access(20'hD7FFF);
        chk("R10 exp_cs", 32'(exp_cs), 1);
        chk("R10 exp_addr", 32'(exp_addr), 32'h3FFFFF);
        wr_win(1'b1, 1'b0, 8'hFF);
        access(20'hD7FFF);
        chk("R3 disarmed base_cs", 32'(base_cs), 1);
        chk("R3 disarmed exp_cs", 32'(exp_cs), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_map();
        t_bounds();
        t_idle();
        t_isolate();
        t_timing();
        t_top();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule